// File: doc/BRIEF.md
# Trailing-Load Block Hold Buffer

In a core that runs two redundant copies of a thread, the trailing copy must read exactly the data the leading copy read. This buffer watches cached loads from the leading thread and the retirement of the matching loads in the trailing thread. For each cache block that still has trailing loads outstanding, it keeps one entry holding the block tag and a count of those loads.

When the cache wants to evict or invalidate a block, it presents the address on the eviction port. The buffer compares the address against its entries. A block with a live entry is refused, and the entry records that an eviction is waiting. When the last outstanding trailing load to that block retires, the entry is freed. If an eviction was waiting on it, the buffer announces the block on a release output so the cache can go ahead. When no entry is free, or when a block's counter is full, the leading load is stalled.

Top module: `ltb_top`

## Requirements
- R1: After reset no block is tracked: `lead_ld_ready_o` is 1, every eviction request is granted, and `release_valid_o` is 0.
- R2: An accepted leading load to an untracked block starts tracking it. From the next cycle on, an eviction request for that block sees `evict_grant_o` at 0 in the same cycle.
- R3: Each accepted leading load to a tracked block adds one outstanding load, and each trailing retirement to it removes one. The block stays held until the retirements equal the loads.
- R4: Blocks are 64 bytes: address bits [5:0] are ignored when matching. An eviction request whose block is not tracked is granted combinationally in the same cycle. `evict_grant_o` is 0 whenever there is no request.
- R5: A refused eviction marks its block as pending. The cycle after the edge where that block's last trailing load retires, `release_valid_o` is 1 for one cycle and `release_addr_o` carries the block address with bits [5:0] at zero. A block that was never refused produces no release.
- R6: A trailing retirement to an untracked block has no effect.
- R7: With all 16 entries in use, a leading load to a new block sees `lead_ld_ready_o` at 0 and is not accepted. A load to a tracked block is still accepted.
- R8: When a block's 4-bit counter is at 15, a further leading load to it sees `lead_ld_ready_o` at 0.
- R9: A leading load and a trailing retirement to the same tracked block in the same cycle leave its count unchanged, so the block stays held.
- R10: An eviction refused in the same cycle as the final retirement still sets pending, and the release follows on the next cycle. A freed entry can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lead_ld_valid_i | input | 1 | Leading-thread cached load issued |
| lead_ld_addr_i | input | ADDR_W | Leading load address |
| lead_ld_ready_o | output | 1 | Load accepted; 0 stalls the leading thread |
| trail_ret_valid_i | input | 1 | Trailing-thread load retired |
| trail_ret_addr_i | input | ADDR_W | Retired load address |
| evict_req_i | input | 1 | Cache asks to replace or invalidate a block |
| evict_addr_i | input | ADDR_W | Address of the block to evict |
| evict_grant_o | output | 1 | Eviction may proceed now |
| release_valid_o | output | 1 | A held, pending block is now free to evict |
| release_addr_o | output | ADDR_W | Block address of the release |

## Verification
`lead_ld_ready_o` and `evict_grant_o` are combinational on the current inputs and the state registered at the last edge. The bench checks them one nanosecond after it drives the inputs at the falling edge, against the model state as it stands before the coming rising edge. The model then applies that edge's loads, retirements and refusals. Any release it predicts is compared in the following cycle, because the release output adds one register. Since state moves only at rising edges and every comparison happens mid-cycle, a load takes effect on grant and ready one cycle later, and a release shows up one cycle after the retirement that caused it.

// File: rtl/ltb_pkg.sv
package ltb_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_OFF_W   = 6;
  localparam int unsigned DEF_CNT_W   = 4;

  typedef enum logic [1:0] {
    EVD_IDLE  = 2'd0,
    EVD_GRANT = 2'd1,
    EVD_DEFER = 2'd2
  } evict_dec_e;
endpackage

// File: rtl/ltb_cam.sv
module ltb_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned TAG_W = 26,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  // tags are unique among valid entries, so an OR encode is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/ltb_free_pick.sv
module ltb_free_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid_i,
  output logic             any_free_o,
  output logic [IDX_W-1:0] free_idx_o
);
  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign any_free_o = ~&valid_i;
endmodule

// File: rtl/ltb_entry.sv
module ltb_entry #(
  parameter int unsigned TAG_W = 26,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             hold_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             release_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TAG_W-1:0] tag_q;
  logic             pend_q, pend_n;

  always_comb begin
    pend_n = pend_q | hold_i;
    if (alloc_i) begin
      cnt_n  = CNT_W'(1);
      pend_n = 1'b0;
    end else begin
      cnt_n = cnt_q + CNT_W'(inc_i) - CNT_W'(dec_i);
    end
    if (cnt_n == '0) pend_n = 1'b0;
  end

  assign valid_o   = (cnt_q != '0);
  assign tag_o     = tag_q;
  assign cnt_o     = cnt_q;
  assign release_o = valid_o && (cnt_n == '0) && (pend_q || hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      if (alloc_i) tag_q <= tag_i;
    end
  end
endmodule

// File: rtl/ltb_top.sv
module ltb_top
  import ltb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned CNT_W   = DEF_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_ld_valid_i,
  input  logic [ADDR_W-1:0] lead_ld_addr_i,
  output logic              lead_ld_ready_o,
  input  logic              trail_ret_valid_i,
  input  logic [ADDR_W-1:0] trail_ret_addr_i,
  input  logic              evict_req_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  output logic              evict_grant_o,
  output logic              release_valid_o,
  output logic [ADDR_W-1:0] release_addr_o
);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_valid, ent_rel;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;
  logic [ENTRIES-1:0]            alloc_v, inc_v, dec_v, hold_v;

  logic [TAG_W-1:0] lead_tag, trail_tag, evict_tag;
  logic             lead_hit, trail_hit, evict_hit, any_free, lead_fire;
  logic [IDX_W-1:0] lead_idx, trail_idx, evict_idx, free_idx;
  evict_dec_e       evict_dec;

  logic             rel_vld_q;
  logic [TAG_W-1:0] rel_tag_q;

  logic unused_offsets;
  assign unused_offsets = ^{lead_ld_addr_i[OFF_W-1:0], trail_ret_addr_i[OFF_W-1:0],
                            evict_addr_i[OFF_W-1:0]};

  assign lead_tag  = lead_ld_addr_i[ADDR_W-1:OFF_W];
  assign trail_tag = trail_ret_addr_i[ADDR_W-1:OFF_W];
  assign evict_tag = evict_addr_i[ADDR_W-1:OFF_W];

  ltb_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_cam_lead (
    .valid_i(ent_valid), .tags_i(ent_tag), .key_i(lead_tag),
    .hit_o(lead_hit), .idx_o(lead_idx)
  );

  ltb_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_cam_trail (
    .valid_i(ent_valid), .tags_i(ent_tag), .key_i(trail_tag),
    .hit_o(trail_hit), .idx_o(trail_idx)
  );

  ltb_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_cam_evict (
    .valid_i(ent_valid), .tags_i(ent_tag), .key_i(evict_tag),
    .hit_o(evict_hit), .idx_o(evict_idx)
  );

  ltb_free_pick #(.N(ENTRIES)) u_free (
    .valid_i(ent_valid), .any_free_o(any_free), .free_idx_o(free_idx)
  );

  // stall on full buffer (new block) or saturated counter (tracked block)
  assign lead_ld_ready_o = lead_hit ? (ent_cnt[lead_idx] != '1) : any_free;
  assign lead_fire       = lead_ld_valid_i && lead_ld_ready_o;

  always_comb begin
    if (!evict_req_i)   evict_dec = EVD_IDLE;
    else if (evict_hit) evict_dec = EVD_DEFER;
    else                evict_dec = EVD_GRANT;
  end

  assign evict_grant_o = (evict_dec == EVD_GRANT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign alloc_v[g] = lead_fire && !lead_hit && (free_idx == IDX_W'(g));
    assign inc_v[g]   = lead_fire && lead_hit && (lead_idx == IDX_W'(g));
    assign dec_v[g]   = trail_ret_valid_i && trail_hit && (trail_idx == IDX_W'(g));
    assign hold_v[g]  = (evict_dec == EVD_DEFER) && (evict_idx == IDX_W'(g));

    ltb_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (alloc_v[g]),
      .tag_i    (lead_tag),
      .inc_i    (inc_v[g]),
      .dec_i    (dec_v[g]),
      .hold_i   (hold_v[g]),
      .valid_o  (ent_valid[g]),
      .tag_o    (ent_tag[g]),
      .cnt_o    (ent_cnt[g]),
      .release_o(ent_rel[g])
    );
  end

  // a release needs a decrement, so only the retiring entry can release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_vld_q <= 1'b0;
      rel_tag_q <= '0;
    end else begin
      rel_vld_q <= |ent_rel;
      if (|ent_rel) rel_tag_q <= ent_tag[trail_idx];
    end
  end

  assign release_valid_o = rel_vld_q;
  assign release_addr_o  = {rel_tag_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/ltb_checker.sv
module ltb_checker #(
  parameter int unsigned OFF_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lead_ld_valid_i,
  input logic             lead_ld_ready_o,
  input logic             trail_ret_valid_i,
  input logic             evict_req_i,
  input logic             evict_grant_o,
  input logic             release_valid_o,
  input logic [OFF_W-1:0] rel_off
);
  logic seen_load_q, seen_refuse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_load_q   <= 1'b0;
      seen_refuse_q <= 1'b0;
    end else begin
      if (lead_ld_valid_i && lead_ld_ready_o) seen_load_q <= 1'b1;
      if (evict_req_i && !evict_grant_o)     seen_refuse_q <= 1'b1;
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_load_q |-> lead_ld_ready_o);

  assert_refuse_needs_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_req_i && !evict_grant_o) |-> seen_load_q);

  assert_grant_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_grant_o |-> evict_req_i);

  assert_release_after_retire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_valid_o |-> $past(trail_ret_valid_i));

  assert_release_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_valid_o |-> (rel_off == '0));

  assert_release_needs_refusal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_valid_o |-> seen_refuse_q);
endmodule

bind ltb_top ltb_checker #(.OFF_W(OFF_W)) u_ltb_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .lead_ld_valid_i  (lead_ld_valid_i),
  .lead_ld_ready_o  (lead_ld_ready_o),
  .trail_ret_valid_i(trail_ret_valid_i),
  .evict_req_i      (evict_req_i),
  .evict_grant_o    (evict_grant_o),
  .release_valid_o  (release_valid_o),
  .rel_off          (release_addr_o[OFF_W-1:0])
);

// File: tb/ltb_top_tb_top.sv
`timescale 1ns/1ps
module ltb_top_tb_top;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 6;
  localparam int CNT_MAX = 15;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lead_ld_valid_i = 1'b0;
  logic [ADDR_W-1:0] lead_ld_addr_i = '0;
  logic              lead_ld_ready_o;
  logic              trail_ret_valid_i = 1'b0;
  logic [ADDR_W-1:0] trail_ret_addr_i = '0;
  logic              evict_req_i = 1'b0;
  logic [ADDR_W-1:0] evict_addr_i = '0;
  logic              evict_grant_o;
  logic              release_valid_o;
  logic [ADDR_W-1:0] release_addr_o;

  always #10 clk_i = ~clk_i;

  ltb_top dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural model: block tag -> outstanding count / pending flag
  int unsigned m_cnt[int unsigned];
  bit          m_pend[int unsigned];
  bit          exp_rel = 0;
  logic [ADDR_W-1:0] exp_rel_addr = '0;

  function automatic int unsigned tg(logic [ADDR_W-1:0] a);
    return int'(a >> OFF_W);
  endfunction

  function automatic logic [ADDR_W-1:0] blk(int n);
    return ADDR_W'(n) << OFF_W;
  endfunction

  task automatic chk(string req, string what, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req, bit lv, logic [ADDR_W-1:0] la, bit tv,
                     logic [ADDR_W-1:0] ta, bit ev, logic [ADDR_W-1:0] ea);
    bit lhit, thit, ehit, rdy, fire;
    lead_ld_valid_i = lv; lead_ld_addr_i = la;
    trail_ret_valid_i = tv; trail_ret_addr_i = ta;
    evict_req_i = ev; evict_addr_i = ea;
    #1;
    lhit = m_cnt.exists(tg(la));
    thit = m_cnt.exists(tg(ta));
    ehit = m_cnt.exists(tg(ea));
    rdy  = lhit ? (m_cnt[tg(la)] != CNT_MAX) : (m_cnt.num() < ENTRIES);
    chk(req, "ready", ADDR_W'(lead_ld_ready_o), ADDR_W'(rdy));
    chk(req, "grant", ADDR_W'(evict_grant_o), ADDR_W'(ev && !ehit));
    chk(req, "rel_valid", ADDR_W'(release_valid_o), ADDR_W'(exp_rel));
    if (exp_rel) chk(req, "rel_addr", release_addr_o, exp_rel_addr);
    // apply the coming edge
    fire = lv && rdy;
    exp_rel = 0;
    if (ev && ehit) m_pend[tg(ea)] = 1;
    if (fire) begin
      if (lhit) m_cnt[tg(la)]++;
      else begin m_cnt[tg(la)] = 1; m_pend[tg(la)] = 0; end
    end
    if (tv && thit) begin
      m_cnt[tg(ta)]--;
      if (m_cnt[tg(ta)] == 0) begin
        if (m_pend[tg(ta)]) begin exp_rel = 1; exp_rel_addr = blk(tg(ta)); end
        m_cnt.delete(tg(ta));
        m_pend.delete(tg(ta));
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(string req);
    cyc(req, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    cyc("R1", 0, '0, 0, '0, 1, blk(7));
    // R2 load then refused eviction
    cyc("R2", 1, blk(1) + 4, 0, '0, 0, '0);
    cyc("R2", 0, '0, 0, '0, 1, blk(1));
    // R5 last retire releases pending block next cycle
    cyc("R5", 0, '0, 1, blk(1) + 8, 0, '0);
    idle("R5");
    cyc("R5", 0, '0, 0, '0, 1, blk(1));
    // R4 offset bits ignored, untracked block granted
    cyc("R4", 1, blk(2), 0, '0, 0, '0);
    cyc("R4", 0, '0, 0, '0, 1, blk(2) + 63);
    cyc("R4", 0, '0, 0, '0, 1, blk(3));
    // R5 block never refused: no release
    cyc("R5", 0, '0, 1, blk(2), 0, '0);
    idle("R5");
    // R3 two loads need two retires
    cyc("R3", 1, blk(4), 0, '0, 0, '0);
    cyc("R3", 1, blk(4) + 1, 0, '0, 0, '0);
    cyc("R3", 0, '0, 1, blk(4), 1, blk(4));
    cyc("R3", 0, '0, 0, '0, 1, blk(4));
    cyc("R3", 0, '0, 1, blk(4), 0, '0);
    cyc("R3", 0, '0, 0, '0, 1, blk(4));
    // R6 retire of untracked block ignored
    cyc("R6", 1, blk(5), 0, '0, 0, '0);
    cyc("R6", 0, '0, 1, blk(6), 0, '0);
    cyc("R6", 0, '0, 0, '0, 1, blk(5));
    cyc("R6", 0, '0, 0, '0, 1, blk(6));
    // R9 same-cycle load and retire keep block held
    cyc("R9", 1, blk(5), 1, blk(5), 0, '0);
    cyc("R9", 0, '0, 0, '0, 1, blk(5));
    // R10 refusal in same cycle as final retire
    cyc("R10", 0, '0, 1, blk(5), 1, blk(5));
    idle("R10");
    cyc("R10", 0, '0, 0, '0, 1, blk(5));
    // R7 full buffer
    for (int i = 0; i < ENTRIES; i++) cyc("R7", 1, blk(100 + i), 0, '0, 0, '0);
    cyc("R7", 1, blk(200), 0, '0, 1, blk(200));
    cyc("R7", 1, blk(100), 0, '0, 0, '0);
    for (int i = 0; i < ENTRIES; i++) cyc("R7", 0, '0, 1, blk(100 + i), 0, '0);
    cyc("R7", 0, '0, 1, blk(100), 1, blk(100));
    idle("R7");
    // R8 counter saturation
    for (int i = 0; i < CNT_MAX; i++) cyc("R8", 1, blk(9), 0, '0, 0, '0);
    cyc("R8", 1, blk(9), 0, '0, 0, '0);
    cyc("R8", 0, '0, 0, '0, 1, blk(9));
    for (int i = 0; i < CNT_MAX; i++) cyc("R8", 0, '0, 1, blk(9), 0, '0);
    idle("R8");
    // R10 freed entries reused
    cyc("R10", 1, blk(300), 0, '0, 0, '0);
    cyc("R10", 0, '0, 0, '0, 1, blk(300));
    cyc("R10", 0, '0, 1, blk(300), 0, '0);
    idle("R10");
    summary();
  end
endmodule